// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit logical address space with 1 KB pages. It takes the 22-bit page number of the missing address and splits it into a 12-bit outer index and a 10-bit inner index. It then makes two dependent reads through a request/response memory port. The first read fetches an outer-table entry. That entry names the inner table, and the second read fetches the leaf entry, which carries the physical frame number. The walker returns either that frame number or a fault code in a one-cycle result pulse.

Two configuration registers are written through a small write port and hold the outer-table base address and the outer-table length. The walker refuses an outer index that is out of range before it touches memory. It also stops at the first entry whose valid bit is clear. A miss is accepted only while the walker is idle, and each walk is strictly sequential.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle (`miss_ready`=1, `mem_req_valid`=0, `res_valid`=0). Table base and length both reset to 0, so any miss accepted before configuration ends with fault code 1.
- R2: The page number is split so that bits [21:10] form the outer index and bits [9:0] form the inner index.
- R3: The first read of a walk goes to address table_base + outer_index*4.
- R4: An outer index greater than or equal to the table length gives fault code 1 (bound) in the cycle after acceptance, with no memory request.
- R5: An outer entry whose bit 0 is 0 ends the walk with fault code 2, with no second read.
- R6: For a valid outer entry E, the second read goes to address {E[31:12], inner_index, 2'b00}.
- R7: A leaf entry whose bit 0 is 0 ends the walk with fault code 3.
- R8: A valid leaf entry L gives fault code 0 and `res_frame`=L[31:10]. The result is a single-cycle pulse, after which the walker is idle again.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change.
- R10: A configuration write (`cfg_sel`=0 for base, 1 for length) takes effect only while the walker is idle. A write made during a walk is ignored.
- R11: A miss is accepted only while `miss_ready` is high. A successful walk issues exactly two memory reads, and a memory request never coincides with `miss_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table length |
| cfg_wdata | input | 32 | Configuration write data (length uses bits [12:0]) |
| miss_valid | input | 1 | Translation miss present |
| miss_vpn | input | 22 | Page number of the missing address |
| miss_ready | output | 1 | Walker idle and able to accept a miss |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (table entry) |
| res_valid | output | 1 | One-cycle result pulse |
| res_code | output | 2 | 0 ok, 1 bound fault, 2 outer invalid, 3 leaf invalid |
| res_frame | output | 22 | Frame number on success, zero on fault |

## Verification
A behavioural reference model predicts every output each cycle. Walks are driven with page numbers whose outer and inner fields differ, so a swapped split or a wrong scale shows up in the addresses. Outer indices sit at length−1, at length and at zero length, which separates an off-by-one in the bound compare from a check that is missing altogether. Chains that fail at the outer level and chains that fail at the leaf level tell the two fault codes apart. A memory that stalls the request and delays the response at random exposes requests that drop or move before acceptance. Configuration writes made during a walk and while idle show whether the write gating works.

// File: rtl/ptw_pkg.sv
// Package ptw_pkg
// Shared state and result encodings for the two-level page table walker.
// Assumes 32-bit table entries whose bit 0 is the valid flag.
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_OUTER = 3'd1,
        ST_WT_OUTER = 3'd2,
        ST_RD_INNER = 3'd3,
        ST_WT_INNER = 3'd4,
        ST_DONE     = 3'd5,
        ST_FAULT    = 3'd6
    } walk_state_e;

    typedef enum logic [1:0] {
        FC_NONE      = 2'd0,
        FC_BOUND     = 2'd1,
        FC_OUTER_INV = 2'd2,
        FC_INNER_INV = 2'd3
    } fault_code_e;

    localparam int ENTRY_SHIFT = 2;

endpackage

// File: rtl/ptw_cfg_regs.sv
// Module ptw_cfg_regs
// Holds the outer-table base address and the outer-table length.
// Assumes the idle flag comes from the walk sequencer; writes outside idle are dropped.
module ptw_cfg_regs #(
    parameter int AW    = 32,
    parameter int LEN_W = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] tbl_base,
    output logic [LEN_W-1:0] tbl_len
);

    // Update base or length only while the sequencer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_base <= '0;
            tbl_len  <= '0;
        end else if (cfg_we && idle) begin
            if (cfg_sel) tbl_len  <= cfg_wdata[LEN_W-1:0];
            else         tbl_base <= cfg_wdata;
        end
    end

    // R10: registers hold while a walk is in progress
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(tbl_base) && $stable(tbl_len)));

endmodule

// File: rtl/ptw_addr_gen.sv
// Module ptw_addr_gen
// Splits the page number into indices, compares the outer index with the
// table length and forms the byte address of the entry to read.
// Assumes inner tables are aligned to their own size (1024 entries of 4 bytes).
module ptw_addr_gen #(
    parameter int AW      = 32,
    parameter int OUTER_W = 12,
    parameter int INNER_W = 10,
    parameter int LEN_W   = OUTER_W + 1,
    parameter int TB_W    = AW - INNER_W - ptw_pkg::ENTRY_SHIFT
) (
    input  logic [OUTER_W+INNER_W-1:0] vpn,
    input  logic [AW-1:0]              tbl_base,
    input  logic [LEN_W-1:0]           tbl_len,
    input  logic [TB_W-1:0]            inner_base,
    input  logic                       sel_inner,
    output logic                       bound_fail,
    output logic [AW-1:0]              req_addr
);

    localparam int PAD_W = AW - OUTER_W - ptw_pkg::ENTRY_SHIFT;

    logic [OUTER_W-1:0] outer_idx;
    logic [INNER_W-1:0] inner_idx;
    logic [AW-1:0]      outer_addr;
    logic [AW-1:0]      inner_addr;

    // Split the page number into its two index fields.
    always_comb begin
        outer_idx = vpn[OUTER_W+INNER_W-1:INNER_W];
        inner_idx = vpn[INNER_W-1:0];
    end

    // Compare the outer index with the configured table length.
    always_comb bound_fail = ({1'b0, outer_idx} >= tbl_len);

    // Form both candidate entry addresses and pick the one for this step.
    always_comb begin
        outer_addr = tbl_base + {{PAD_W{1'b0}}, outer_idx, {ptw_pkg::ENTRY_SHIFT{1'b0}}};
        inner_addr = {inner_base, inner_idx, {ptw_pkg::ENTRY_SHIFT{1'b0}}};
        req_addr   = sel_inner ? inner_addr : outer_addr;
    end

endmodule

// File: rtl/ptw_fsm.sv
// Module ptw_fsm
// Sequences one walk: accept, outer read, inner read, result pulse.
// Assumes one outstanding memory read and a response some cycles after acceptance.
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int AW      = 32,
    parameter int OUTER_W = 12,
    parameter int INNER_W = 10,
    parameter int VPN_W   = OUTER_W + INNER_W,
    parameter int OFFS_W  = AW - VPN_W,
    parameter int FRAME_W = AW - OFFS_W,
    parameter int TB_W    = AW - INNER_W - ENTRY_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [VPN_W-1:0]   miss_vpn,
    input  logic               bound_fail,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [AW-1:0]      mem_rsp_data,
    output logic               miss_ready,
    output logic               mem_req_valid,
    output logic               sel_inner,
    output logic [VPN_W-1:0]   cur_vpn,
    output logic [TB_W-1:0]    inner_base,
    output logic               res_valid,
    output logic [1:0]         res_code,
    output logic [FRAME_W-1:0] res_frame
);

    walk_state_e        state, state_nx;
    logic [VPN_W-1:0]   vpn_q;
    logic [TB_W-1:0]    tbase_q;
    fault_code_e        code_q;
    logic [FRAME_W-1:0] frame_q;
    logic               rsp_ok;
    logic               accept;
    logic               unused_rsp_bits;

    assign unused_rsp_bits = ^mem_rsp_data[OFFS_W-1:1];

    // Decode handshakes and the entry valid flag.
    always_comb begin
        rsp_ok = mem_rsp_data[0];
        accept = (state == ST_IDLE) && miss_valid;
    end

    // Next-state selection for the walk sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:     if (miss_valid) state_nx = bound_fail ? ST_FAULT : ST_RD_OUTER;
            ST_RD_OUTER: if (mem_req_ready) state_nx = ST_WT_OUTER;
            ST_WT_OUTER: if (mem_rsp_valid) state_nx = rsp_ok ? ST_RD_INNER : ST_FAULT;
            ST_RD_INNER: if (mem_req_ready) state_nx = ST_WT_INNER;
            ST_WT_INNER: if (mem_rsp_valid) state_nx = rsp_ok ? ST_DONE : ST_FAULT;
            ST_DONE:     state_nx = ST_IDLE;
            ST_FAULT:    state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the page number, the inner table base and the result fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            tbase_q <= '0;
            code_q  <= FC_NONE;
            frame_q <= '0;
        end else begin
            if (accept) begin
                vpn_q   <= miss_vpn;
                frame_q <= '0;
                code_q  <= bound_fail ? FC_BOUND : FC_NONE;
            end
            if (state == ST_WT_OUTER && mem_rsp_valid) begin
                if (rsp_ok) tbase_q <= mem_rsp_data[AW-1:AW-TB_W];
                else        code_q  <= FC_OUTER_INV;
            end
            if (state == ST_WT_INNER && mem_rsp_valid) begin
                if (rsp_ok) begin
                    code_q  <= FC_NONE;
                    frame_q <= mem_rsp_data[AW-1:OFFS_W];
                end else begin
                    code_q  <= FC_INNER_INV;
                end
            end
        end
    end

    // Drive handshake, address-select and result outputs from the state.
    always_comb begin
        miss_ready    = (state == ST_IDLE);
        mem_req_valid = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
        sel_inner     = (state == ST_RD_INNER);
        cur_vpn       = (state == ST_IDLE) ? miss_vpn : vpn_q;
        inner_base    = tbase_q;
        res_valid     = (state == ST_DONE) || (state == ST_FAULT);
        res_code      = code_q;
        res_frame     = frame_q;
    end

    // R8: result is a single pulse followed by idle
    a_r8_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && miss_ready));

    // R4: bound fault reported next cycle without a memory request
    a_r4_bound_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && bound_fail) |=>
        (res_valid && res_code == FC_BOUND && !mem_req_valid));

    // R5: invalid outer entry stops the walk with code 2
    a_r5_outer_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WT_OUTER && mem_rsp_valid && !mem_rsp_data[0]) |=>
        (res_valid && res_code == FC_OUTER_INV));

    // R11: no request while the walker offers to accept a miss
    a_r11_req_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !miss_ready);

endmodule

// File: rtl/pt_walker.sv
// Module pt_walker
// Top of the two-level page table walker: configuration registers, index
// and address generation, and the walk sequencer.
// Assumes the memory port keeps a single read outstanding and answers it in order.
module pt_walker #(
    parameter int AW      = 32,
    parameter int OUTER_W = 12,
    parameter int INNER_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_sel,
    input  logic [AW-1:0]             cfg_wdata,
    input  logic                      miss_valid,
    input  logic [OUTER_W+INNER_W-1:0] miss_vpn,
    output logic                      miss_ready,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic [AW-1:0]             mem_req_addr,
    input  logic                      mem_rsp_valid,
    input  logic [AW-1:0]             mem_rsp_data,
    output logic                      res_valid,
    output logic [1:0]                res_code,
    output logic [OUTER_W+INNER_W-1:0] res_frame
);

    localparam int VPN_W = OUTER_W + INNER_W;
    localparam int LEN_W = OUTER_W + 1;
    localparam int TB_W  = AW - INNER_W - ptw_pkg::ENTRY_SHIFT;

    logic [AW-1:0]    tbl_base;
    logic [LEN_W-1:0] tbl_len;
    logic [VPN_W-1:0] cur_vpn;
    logic [TB_W-1:0]  inner_base;
    logic             sel_inner;
    logic             bound_fail;

    ptw_cfg_regs #(.AW(AW), .LEN_W(LEN_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (miss_ready),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .tbl_base  (tbl_base),
        .tbl_len   (tbl_len)
    );

    ptw_addr_gen #(.AW(AW), .OUTER_W(OUTER_W), .INNER_W(INNER_W), .LEN_W(LEN_W), .TB_W(TB_W)) u_addr (
        .vpn        (cur_vpn),
        .tbl_base   (tbl_base),
        .tbl_len    (tbl_len),
        .inner_base (inner_base),
        .sel_inner  (sel_inner),
        .bound_fail (bound_fail),
        .req_addr   (mem_req_addr)
    );

    ptw_fsm #(.AW(AW), .OUTER_W(OUTER_W), .INNER_W(INNER_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_vpn      (miss_vpn),
        .bound_fail    (bound_fail),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .miss_ready    (miss_ready),
        .mem_req_valid (mem_req_valid),
        .sel_inner     (sel_inner),
        .cur_vpn       (cur_vpn),
        .inner_base    (inner_base),
        .res_valid     (res_valid),
        .res_code      (res_code),
        .res_frame     (res_frame)
    );

    // R9: a stalled request keeps its valid and its address
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_sel;
    logic [31:0] cfg_wdata;
    logic        miss_valid;
    logic [21:0] miss_vpn;
    logic        miss_ready;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic [1:0]  res_code;
    logic [21:0] res_frame;

    always #(CLK_P/2) clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .miss_valid(miss_valid), .miss_vpn(miss_vpn), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_code(res_code), .res_frame(res_frame)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [int unsigned];

    // behavioural reference model
    int          m_phase;   // 0 idle,1 outer req,2 outer wait,3 inner req,4 inner wait,5 result
    logic [31:0] m_base, m_oent;
    logic [12:0] m_len;
    logic [21:0] m_vpn, m_frame;
    logic [1:0]  m_code;

    // memory responder and observations
    int          rdy_pct = 100, lat = 0, cnt = 0;
    bit          pend = 0, prev_rv = 0;
    logic [31:0] prev_addr, pdata;
    int          req_cnt, res_seen;
    logic [31:0] obs_outer, obs_inner;
    logic [1:0]  obs_code;
    logic [21:0] obs_frame;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic step();
        bit hs;
        bit was_idle;
        @(negedge clk);
        hs = prev_rv && mem_req_ready;
        was_idle = (m_phase == 0);
        // advance the model with the inputs seen at the edge
        case (m_phase)
            0: if (miss_valid) begin
                   m_vpn = miss_vpn; m_frame = '0;
                   if ({1'b0, miss_vpn[21:10]} >= m_len) begin m_code = 2'd1; m_phase = 5; end
                   else m_phase = 1;
               end
            1: if (mem_req_ready) m_phase = 2;
            2: if (mem_rsp_valid) begin
                   if (!mem_rsp_data[0]) begin m_code = 2'd2; m_phase = 5; end
                   else begin m_oent = mem_rsp_data; m_phase = 3; end
               end
            3: if (mem_req_ready) m_phase = 4;
            4: if (mem_rsp_valid) begin
                   if (!mem_rsp_data[0]) m_code = 2'd3;
                   else begin m_code = 2'd0; m_frame = mem_rsp_data[31:10]; end
                   m_phase = 5;
               end
            default: m_phase = 0;
        endcase
        if (was_idle && cfg_we) begin
            if (cfg_sel) m_len = cfg_wdata[12:0];
            else         m_base = cfg_wdata;
        end
        if (hs) begin
            pend = 1; cnt = lat; pdata = rd(prev_addr); req_cnt++;
        end
        // compare every output with the model
        chk(miss_ready === (m_phase == 0), "R11 miss_ready", 64'(miss_ready), 64'(m_phase == 0));
        chk(mem_req_valid === (m_phase == 1 || m_phase == 3), "R9 mem_req_valid",
            64'(mem_req_valid), 64'(m_phase == 1 || m_phase == 3));
        chk(res_valid === (m_phase == 5), "R8 res_valid", 64'(res_valid), 64'(m_phase == 5));
        if (m_phase == 1) begin
            chk(mem_req_addr === m_base + {18'd0, m_vpn[21:10], 2'b00}, "R3 outer addr",
                64'(mem_req_addr), 64'(m_base + {18'd0, m_vpn[21:10], 2'b00}));
            obs_outer = mem_req_addr;
        end
        if (m_phase == 3) begin
            chk(mem_req_addr === {m_oent[31:12], m_vpn[9:0], 2'b00}, "R6 inner addr",
                64'(mem_req_addr), 64'({m_oent[31:12], m_vpn[9:0], 2'b00}));
            obs_inner = mem_req_addr;
        end
        if (prev_rv && !hs)
            chk(mem_req_valid && mem_req_addr === prev_addr, "R9 stall hold",
                64'(mem_req_addr), 64'(prev_addr));
        if (m_phase == 5) begin
            chk(res_code === m_code, "R8 res_code", 64'(res_code), 64'(m_code));
            chk(res_frame === m_frame, "R8 res_frame", 64'(res_frame), 64'(m_frame));
            obs_code = res_code; obs_frame = res_frame; res_seen++;
        end
        // drive memory-side inputs for the next edge
        if (pend && cnt == 0) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = pdata; pend = 0;
        end else begin
            mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
            if (pend) cnt--;
        end
        mem_req_ready = ($urandom_range(99, 0) < rdy_pct);
        prev_rv = mem_req_valid;
        prev_addr = mem_req_addr;
    endtask

    task automatic cfg_write(input bit sel, input logic [31:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_we = 0;
    endtask

    task automatic walk(input logic [21:0] vpn, input bit midwrite);
        req_cnt = 0; res_seen = 0; obs_outer = 'x; obs_inner = 'x;
        miss_valid = 1; miss_vpn = vpn;
        step();
        miss_valid = 0;
        if (midwrite) begin
            cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'h5000;
            step();
            cfg_we = 1; cfg_sel = 1; cfg_wdata = 32'h0;
            step();
            cfg_we = 0;
        end
        for (int i = 0; i < 200 && res_seen == 0; i++) step();
        step();
        chk(res_seen == 1, "R8 one result per walk", 64'(res_seen), 64'd1);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; miss_valid = 0; miss_vpn = 0;
        mem_req_ready = 1; mem_rsp_valid = 0; mem_rsp_data = 0;
        m_phase = 0; m_base = 0; m_len = 0; m_oent = 0; m_vpn = 0; m_frame = 0; m_code = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(miss_ready === 1'b1, "R1 miss_ready", 64'(miss_ready), 64'd1);
        chk(mem_req_valid === 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk(res_valid === 1'b0, "R1 res_valid", 64'(res_valid), 64'd0);
        prev_rv = 0;
        walk(22'h0, 0);
        chk(obs_code == 2'd1 && req_cnt == 0, "R1 unconfigured bound fault", 64'(obs_code), 64'd1);

        // table image
        mem[32'h100C] = 32'h0002_0001;                 // outer 3 -> inner table 0x20000
        mem[32'h2_0014] = (32'h12345 << 10) | 32'h1;   // inner 5
        mem[32'h1000 + 15*4] = 32'h0003_0001;          // outer 15 -> 0x30000
        mem[32'h3_0000 + 1023*4] = (32'h3FFFFF << 10) | 32'h1;
        mem[32'h1000 + 7*4] = 32'h0004_0000;           // outer 7 invalid
        cfg_write(0, 32'h1000);
        cfg_write(1, 32'd16);

        // R2, R3, R6, R8, R11: valid chain, distinct fields
        walk({12'd3, 10'd5}, 0);
        chk(obs_outer == 32'h100C, "R2 R3 outer address", 64'(obs_outer), 64'h100C);
        chk(obs_inner == 32'h2_0014, "R6 inner address", 64'(obs_inner), 64'h20014);
        chk(obs_code == 2'd0 && obs_frame == 22'h12345, "R8 frame", 64'(obs_frame), 64'h12345);
        chk(req_cnt == 2, "R11 two reads", 64'(req_cnt), 64'd2);

        // R4 boundary: length-1 passes, length faults
        walk({12'd15, 10'd1023}, 0);
        chk(obs_code == 2'd0 && obs_frame == 22'h3FFFFF, "R4 last index ok", 64'(obs_frame), 64'h3FFFFF);
        walk({12'd16, 10'd0}, 0);
        chk(obs_code == 2'd1 && req_cnt == 0, "R4 bound fault no read", 64'(req_cnt), 64'd0);

        // R5 outer invalid, R7 leaf invalid
        walk({12'd7, 10'd2}, 0);
        chk(obs_code == 2'd2 && req_cnt == 1, "R5 outer invalid", 64'(obs_code), 64'd2);
        walk({12'd3, 10'd6}, 0);
        chk(obs_code == 2'd3 && req_cnt == 2, "R7 leaf invalid", 64'(obs_code), 64'd3);

        // R9: stalls and latency
        rdy_pct = 30; lat = 3;
        walk({12'd3, 10'd5}, 0);
        chk(obs_frame == 22'h12345, "R9 stalled walk frame", 64'(obs_frame), 64'h12345);
        rdy_pct = 100; lat = 0;

        // R10: writes during a walk are ignored, idle writes apply
        walk({12'd3, 10'd5}, 1);
        walk({12'd3, 10'd5}, 0);
        chk(obs_outer == 32'h100C && obs_code == 2'd0, "R10 mid-walk write ignored", 64'(obs_outer), 64'h100C);
        mem[32'h200C] = 32'h0002_0001;
        cfg_write(0, 32'h2000);
        walk({12'd3, 10'd5}, 0);
        chk(obs_outer == 32'h200C, "R10 idle write applies", 64'(obs_outer), 64'h200C);
        cfg_write(0, 32'h1000);

        // random stress against the model
        for (int k = 0; k < 300; k++) begin
            rdy_pct = $urandom_range(100, 20);
            lat = $urandom_range(3, 0);
            case ($urandom_range(3, 0))
                0: walk({12'd3, 10'd5}, 0);
                1: walk({12'd15, 10'd1023}, 0);
                2: walk({12'($urandom_range(20, 0)), 10'($urandom)}, 0);
                default: walk(22'($urandom), 0);
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule